// File: doc/BRIEF.md
# I2C Register-File Target

This block is the target side of a two-wire serial bus, with a small bank of byte-wide registers behind it. It passes both bus lines through a synchronizer that runs on the system clock. It watches for a START condition and compares the 7-bit device address that follows with its own address. It answers only when the address matches. The data line is open-drain: the block either pulls it low or lets it go. It never drives it high.

A write transfer carries a pointer byte first, and every byte after it is data stored at the pointer. A read transfer shifts register contents out, most significant bit first. A STOP returns the pointer to zero. A repeated START leaves the pointer where it is. A master can therefore read any register by writing only the pointer, issuing a repeated START, and then reading.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset the block releases SDA, the pointer is 0 and every register reads 0x00.
- R2: A START is SDA falling while SCL is high. The eight bits after it are sampled on SCL rising edges, MSB first: a 7-bit address and then a direction bit (0 = write, 1 = read). When the address equals DEV_ADDR (default 0x4C), the block pulls SDA low through the whole ninth clock.
- R3: When the address does not match, the block does not acknowledge. It keeps SDA released and writes no register until the next START.
- R4: In a write, the first byte after the address is acknowledged and loads the pointer from its low log2(NUM_REGS) bits. The higher bits are ignored.
- R5: Each later byte of a write is acknowledged and stored in the register the pointer selects. The pointer then advances by one and wraps from NUM_REGS-1 to 0.
- R6: A STOP (SDA rising while SCL is high) clears the pointer to 0. A write that carries only a pointer byte changes no register, and a following read starts at register 0.
- R7: A repeated START keeps the pointer. A read after it starts at the register named by the pointer byte just written.
- R8: In a read, the block shifts out the selected register MSB first and releases SDA for 1 bits. It releases SDA during the ninth clock so the master can acknowledge. The pointer advances, with wrap, after each byte sent.
- R9: When the master does not acknowledge (SDA high on the ninth clock), the block keeps SDA released until the next START or STOP.
- R10: The SDA output changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions take for granted a master that changes SDA only while SCL is low, apart from START and STOP. They also assume every SCL high and low phase lasts several system clocks longer than the synchronizer delay, so that the block's reaction to an SCL edge lands before the next edge. The bench drives the bus with a quarter-bit of ten system clocks and changes SDA only at the start of each low phase. It changes SDA while SCL is high only to form START and STOP. The bench models the bus as a wired-AND of its own driver and the block's pull-down.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    // STAGES must be at least 2
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    logic scl_cur, sda_cur;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[STAGES-2:0], scl_i};
        sync_d.sda_sh   = {sync_q.sda_sh[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl_sh[STAGES-1];
        sync_d.sda_prev = sync_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_cur    = sync_q.scl_sh[STAGES-1];
    assign sda_cur    = sync_q.sda_sh[STAGES-1];
    assign scl_o      = scl_cur;
    assign sda_o      = sda_cur;
    assign scl_rise_o = scl_cur & ~sync_q.scl_prev;
    assign scl_fall_o = ~scl_cur & sync_q.scl_prev;
    assign start_o    = scl_cur & sync_q.scl_prev & sync_q.sda_prev & ~sda_cur;
    assign stop_o     = scl_cur & sync_q.scl_prev & ~sync_q.sda_prev & sda_cur;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NUM_REGS = 8,
    parameter int DW       = 8,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_d [NUM_REGS];
    logic [DW-1:0] mem_q [NUM_REGS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R5: a write strobe leaves its byte in the addressed register
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4C,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);

    // NUM_REGS: power of two, at most 128
    localparam int PW = $clog2(NUM_REGS);
    localparam logic [PW-1:0] PTR_ONE = PW'(1);

    typedef struct packed {
        tgt_state_e    state;
        tgt_state_e    after_ack;
        logic [3:0]    cnt;
        logic [7:0]    shreg;
        logic [PW-1:0] ptr;
        logic          pull;
        logic          mack;
    } core_t;

    core_t core_d, core_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic          wr_en;
    logic [7:0]    rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_p),
        .stop_o     (stop_p)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DW(8)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (core_q.ptr),
        .wr_data (core_q.shreg),
        .rd_addr (core_q.ptr),
        .rd_data (rd_data)
    );

    always_comb begin
        core_d = core_q;
        wr_en  = 1'b0;
        if (stop_p) begin
            core_d.state = ST_IDLE;
            core_d.ptr   = '0;
            core_d.pull  = 1'b0;
            core_d.cnt   = '0;
        end else if (start_p) begin
            core_d.state = ST_ADDR;
            core_d.pull  = 1'b0;
            core_d.cnt   = '0;
        end else begin
            unique case (core_q.state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && core_q.cnt < 4'd8) begin
                        core_d.shreg = {core_q.shreg[6:0], sda_s};
                        core_d.cnt   = core_q.cnt + 4'd1;
                    end else if (scl_fall && core_q.cnt == 4'd8) begin
                        core_d.cnt = '0;
                        if (core_q.state == ST_ADDR) begin
                            if (core_q.shreg[7:1] == DEV_ADDR) begin
                                core_d.pull      = 1'b1;
                                core_d.state     = ST_ACK;
                                core_d.after_ack = core_q.shreg[0] ? ST_RDATA : ST_PTR;
                            end else begin
                                core_d.state = ST_WAIT;
                            end
                        end else if (core_q.state == ST_PTR) begin
                            core_d.ptr       = core_q.shreg[PW-1:0];
                            core_d.pull      = 1'b1;
                            core_d.state     = ST_ACK;
                            core_d.after_ack = ST_WDATA;
                        end else begin
                            wr_en            = 1'b1;
                            core_d.ptr       = core_q.ptr + PTR_ONE;
                            core_d.pull      = 1'b1;
                            core_d.state     = ST_ACK;
                            core_d.after_ack = ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        core_d.pull  = 1'b0;
                        core_d.cnt   = '0;
                        core_d.state = core_q.after_ack;
                        if (core_q.after_ack == ST_RDATA) begin
                            core_d.shreg = rd_data;
                            core_d.pull  = ~rd_data[7];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        core_d.cnt = core_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (core_q.cnt == 4'd8) begin
                            core_d.pull  = 1'b0;
                            core_d.state = ST_RACK;
                            core_d.ptr   = core_q.ptr + PTR_ONE;
                            core_d.cnt   = '0;
                        end else begin
                            core_d.shreg = {core_q.shreg[6:0], 1'b0};
                            core_d.pull  = ~core_q.shreg[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        core_d.mack = ~sda_s;
                        core_d.cnt  = 4'd1;
                    end else if (scl_fall && core_q.cnt == 4'd1) begin
                        core_d.cnt = '0;
                        if (core_q.mack) begin
                            core_d.shreg = rd_data;
                            core_d.pull  = ~rd_data[7];
                            core_d.state = ST_RDATA;
                        end else begin
                            core_d.state = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q           <= '0;
            core_q.state     <= ST_IDLE;
            core_q.after_ack <= ST_IDLE;
        end else begin
            core_q <= core_d;
        end
    end

    assign sda_pull_o = core_q.pull;

    // R10: the pull-down toggles only after SCL was seen low
    a_r10_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.pull != $past(core_q.pull)) |-> !$past(scl_s));

    // R3 / R9: idle or ignoring the bus means SDA released
    a_r3_quiet_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_WAIT || core_q.state == ST_IDLE) |-> !core_q.pull);

    // R6: STOP clears the pointer
    a_r6_stop_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (core_q.ptr == '0 && core_q.state == ST_IDLE));

    // R7: repeated START keeps the pointer
    a_r7_restart_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && !stop_p) |=> core_q.ptr == $past(core_q.ptr));

    // R8: SDA is left to the master during its acknowledge slot
    a_r8_release_for_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_RACK) |-> !core_q.pull);

endmodule

// File: tb/i2c_regfile_target_bench.sv
module i2c_regfile_target_bench;

    localparam int         NREG = 8;
    localparam logic [6:0] DEV  = 7'h4C;
    localparam int         Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic sda_bus;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;

    i2c_regfile_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .SYNC_STAGES(2)) u_i2c_regfile_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull)
    );

    int checks = 0;
    int fails  = 0;
    int bad_r10 = 0;
    int bad_quiet = 0;
    logic quiet_exp = 1'b0;
    logic prev_pull = 1'b0;

    logic [7:0] model [NREG];
    logic [7:0] wq[$];

    // per-clock comparison against the behavioural expectations
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_pull != prev_pull && m_scl) bad_r10++;
            if (quiet_exp && sda_pull) bad_quiet++;
        end
        prev_pull = sda_pull;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq_step();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq_step();
        m_scl = 1'b1; wq_step();
        m_sda = 1'b0; wq_step();
        m_scl = 1'b0; wq_step();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq_step();
        m_scl = 1'b1; wq_step();
        m_sda = 1'b1; wq_step();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq_step();
            m_scl = 1'b1; wq_step();
            m_scl = 1'b0; wq_step();
        end
        m_sda = 1'b1; wq_step();
        m_scl = 1'b1; wq_step();
        acked = ~sda_bus;
        m_scl = 1'b0; wq_step();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq_step();
            m_scl = 1'b1; wq_step();
            d[i] = sda_bus;
            m_scl = 1'b0; wq_step();
        end
        m_sda = ~give_ack; wq_step();
        m_scl = 1'b1; wq_step();
        chk("R8 release in master ack slot", int'(sda_pull), 0);
        m_scl = 1'b0; wq_step();
    endtask

    // write the bytes in wq starting at pointer byte p
    task automatic write_regs(input logic [7:0] p);
        logic ak;
        int   ep;
        bus_start();
        put_byte({DEV, 1'b0}, ak); chk("R2 write address ack", int'(ak), 1);
        put_byte(p, ak);           chk("R4 pointer byte ack", int'(ak), 1);
        ep = int'(p) % NREG;
        foreach (wq[k]) begin
            put_byte(wq[k], ak);   chk("R5 data byte ack", int'(ak), 1);
            model[ep] = wq[k];
            ep = (ep + 1) % NREG;
        end
        bus_stop();
    endtask

    // random-access read of n bytes starting at pointer byte p
    task automatic read_regs(input logic [7:0] p, input int n);
        logic ak;
        logic [7:0] d;
        int   ep;
        bus_start();
        put_byte({DEV, 1'b0}, ak); chk("R2 write address ack", int'(ak), 1);
        put_byte(p, ak);           chk("R4 pointer byte ack", int'(ak), 1);
        bus_start();
        put_byte({DEV, 1'b1}, ak); chk("R7 read address ack after restart", int'(ak), 1);
        ep = int'(p) % NREG;
        for (int k = 0; k < n; k++) begin
            get_byte(k < n - 1, d);
            chk("R8 read data", int'(d), int'(model[ep]));
            ep = (ep + 1) % NREG;
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: released after reset, registers clear
        chk("R1 SDA released after reset", int'(sda_pull), 0);
        read_regs(8'h00, 4);

        // R5: plain writes, several patterns
        wq.delete(); wq.push_back(8'h5A); write_regs(8'h00);
        wq.delete(); wq.push_back(8'hC3); write_regs(8'h05);
        wq.delete(); wq.push_back(8'hA5); wq.push_back(8'h3C); write_regs(8'h02);
        read_regs(8'h02, 2);

        // R3: foreign address is ignored
        bus_start();
        quiet_exp = 1'b1;
        put_byte({7'h4D, 1'b0}, ak); chk("R3 no ack on foreign address", int'(ak), 0);
        put_byte(8'h02, ak);         chk("R3 no ack after mismatch", int'(ak), 0);
        put_byte(8'hFF, ak);         chk("R3 no ack after mismatch", int'(ak), 0);
        quiet_exp = 1'b0;
        bus_stop();
        read_regs(8'h02, 2);

        // R6: pointer-only write then STOP, read starts at 0
        bus_start();
        put_byte({DEV, 1'b0}, ak); chk("R6 address ack", int'(ak), 1);
        put_byte(8'h05, ak);       chk("R6 pointer ack", int'(ak), 1);
        bus_stop();
        bus_start();
        put_byte({DEV, 1'b1}, ak); chk("R6 read address ack", int'(ak), 1);
        get_byte(1'b0, d);
        chk("R6 read after STOP starts at reg 0", int'(d), int'(model[0]));
        bus_stop();
        read_regs(8'h05, 1);

        // R9: after NACK the block stays silent
        bus_start();
        put_byte({DEV, 1'b0}, ak);
        put_byte(8'h02, ak);
        bus_start();
        put_byte({DEV, 1'b1}, ak);
        get_byte(1'b0, d); chk("R9 byte before NACK", int'(d), int'(model[2]));
        quiet_exp = 1'b1;
        get_byte(1'b0, d); chk("R9 bus idle high after NACK", int'(d), 8'hFF);
        quiet_exp = 1'b0;
        bus_stop();

        // R5 / R8: pointer wraps at the top of the bank
        wq.delete(); wq.push_back(8'h11); wq.push_back(8'h22); write_regs(8'(NREG - 1));
        read_regs(8'(NREG - 1), 2);

        // R4: upper pointer bits ignored
        wq.delete(); wq.push_back(8'h77); write_regs(8'h7B);
        read_regs(8'h03, 1);
        wq.delete(); wq.push_back(8'h80); wq.push_back(8'h01); write_regs(8'h04);
        read_regs(8'h04, 3);

        chk("R10 SDA output moved only while SCL low", bad_r10, 0);
        chk("R3 R9 SDA released when expected", bad_quiet, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule